// File: doc/BRIEF.md
# Command-Block Controller Register Window

This block is the processor-facing side of a disk-style controller. It occupies eight consecutive IO addresses and decodes the low three address bits. Reads return a status word. Writes load a control word or one of the two halves of a 24-bit pointer to a command block in memory. The command engine behind the window is started and aborted through single-cycle pulses. It reports completion on a done input. The window raises an interrupt request from that completion, or at once when interrupts are enabled while the controller is already ready.

One access is presented per cycle with `acc_valid`. Every effect of an access, including read data, status changes, pulses and the interrupt line, is registered. Each one appears on the ports in the cycle after the clock edge that samples the access.

Top module: `cbw_top`

## Requirements
- R1: After reset the status word is 0x8008 (dual-density bit 15 and ready bit 3 only), `irq` is low and both engine pulses are low.
- R2: A read of offset 0, or of any offset other than 2, returns 0 on `rd_data` in the cycle after the access.
- R3: A read of offset 2 returns the status word: bit 1 interrupt enabled, bit 2 active, bit 3 ready, bit 4 OR of all error flags, bit 6 hard engine error, bit 15 always 1, every other bit 0.
- R4: A control write (offset 3) with bit 8 set, while not active, pulses `eng_start` for one cycle and sets active and clears ready. All other bits of that word are ignored. While active, such a write has no effect.
- R5: A control write with bit 8 clear and bit 1 set sets the interrupt-enable status bit. If ready was set and interrupt enable was clear, `irq` rises in the same update.
- R6: `eng_done` while active clears active and sets ready. If interrupt enable is set, `irq` rises.
- R7: `irq` stays high until a read of offset 2 drops it.
- R8: A control write with bits 8 and 1 clear and bit 4 set returns status to 0x8008, drops `irq` and pulses `eng_clear` for one cycle.
- R9: A write to offset 5 loads bits 23:16 of `cb_ptr` from data bits 7:0. A write to offset 7 loads bits 15:0. No other access changes `cb_ptr`.
- R10: A control write with none of bits 8, 1, 4 set, or any read or write of offset 4 or 6, sets the unsupported-access flag. Status bit 4 is then held until a device clear.
- R11: `eng_done` together with `eng_hard_err` while active sets status bits 6 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| acc_valid | input | 1 | An IO access is presented this cycle |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| acc_addr | input | 3 | Offset within the eight-address window |
| acc_wdata | input | 16 | Write data |
| rd_data | output | 16 | Read data, valid the cycle after a read |
| irq | output | 1 | Interrupt request level |
| eng_start | output | 1 | One-cycle start pulse to the command engine |
| eng_clear | output | 1 | One-cycle abort pulse to the command engine |
| cb_ptr | output | 24 | Command-block pointer |
| eng_done | input | 1 | Command engine finished |
| eng_hard_err | input | 1 | Engine finished with a hard transfer error, qualified by eng_done |

## Verification
Every result of an access or of `eng_done` is due exactly one clock after the edge that samples it. This covers read data, status flags, `irq`, both engine pulses and the pointer. The bench drives each stimulus on a falling edge and removes it on the next falling edge. It samples outputs at that second falling edge, half a cycle after the register update, and checks there. A status read then follows to observe flags through the port. Because that read also drops `irq`, the bench compares `irq` before issuing it.

// File: rtl/cbw_pkg.sv
package cbw_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 3;
  localparam int PTR_W  = 24;

  // register offsets (low address bits)
  localparam int OFS_DATA = 0;
  localparam int OFS_STAT = 2;
  localparam int OFS_CTRL = 3;
  localparam int OFS_BAD0 = 4;
  localparam int OFS_PHI  = 5;
  localparam int OFS_BAD1 = 6;
  localparam int OFS_PLO  = 7;

  // status bit positions
  localparam int SB_IE   = 1;
  localparam int SB_ACT  = 2;
  localparam int SB_RDY  = 3;
  localparam int SB_ERR  = 4;
  localparam int SB_HARD = 6;
  localparam int SB_DENS = 15;

  // control word bit positions
  localparam int CB_IE    = 1;
  localparam int CB_CLR   = 4;
  localparam int CB_FETCH = 8;

  typedef struct packed {
    logic ie;
    logic act;
    logic rdy;
    logic unsup;
    logic hard;
  } stat_t;

  localparam stat_t STAT_RST = '{ie: 1'b0, act: 1'b0, rdy: 1'b1, unsup: 1'b0, hard: 1'b0};
endpackage

// File: rtl/cbw_decode.sv
module cbw_decode
  import cbw_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic          acc_write,
  input  logic [AW-1:0] acc_addr,
  output logic          rd_stat,
  output logic          wr_ctrl,
  output logic          wr_phi,
  output logic          wr_plo,
  output logic          bad_acc
);
  localparam int NOFS = 1 << AW;

  logic [NOFS-1:0] sel;

  for (genvar g = 0; g < NOFS; g++) begin : g_sel
    assign sel[g] = acc_valid && (acc_addr == AW'(g));
  end

  assign rd_stat = sel[OFS_STAT] && !acc_write;
  assign wr_ctrl = sel[OFS_CTRL] && acc_write;
  assign wr_phi  = sel[OFS_PHI]  && acc_write;
  assign wr_plo  = sel[OFS_PLO]  && acc_write;
  assign bad_acc = sel[OFS_BAD0] || sel[OFS_BAD1];

  p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_stat, wr_ctrl, wr_phi, wr_plo, bad_acc}));
endmodule

// File: rtl/cbw_ptr.sv
module cbw_ptr
  import cbw_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int PW = PTR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_hi,
  input  logic          wr_lo,
  input  logic [DW-1:0] wdata,
  output logic [PW-1:0] ptr
);
  localparam int HW = PW - DW;

  logic [HW-1:0] hi_q, hi_n;
  logic [DW-1:0] lo_q, lo_n;

  always_comb begin
    hi_n = hi_q;
    lo_n = lo_q;
    if (wr_hi) hi_n = wdata[HW-1:0];
    if (wr_lo) lo_n = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      if (wr_hi) hi_q <= hi_n;
      if (wr_lo) lo_q <= lo_n;
    end
  end

  assign ptr = {hi_q, lo_q};

  p_ptr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_hi && !wr_lo) |=> $stable(ptr));
endmodule

// File: rtl/cbw_ctl.sv
module cbw_ctl
  import cbw_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_any,
  input  logic          rd_stat,
  input  logic          wr_ctrl,
  input  logic          bad_acc,
  input  logic [DW-1:0] wdata,
  input  logic          eng_done,
  input  logic          eng_hard_err,
  output logic [DW-1:0] rd_data,
  output logic          irq,
  output logic          eng_start,
  output logic          eng_clear
);
  stat_t         st_q, st_n;
  logic          irq_q, irq_n;
  logic          start_q, start_n;
  logic          clr_q, clr_n;
  logic [DW-1:0] rd_q, rd_n;
  logic [DW-1:0] stat_word;

  always_comb begin
    stat_word          = '0;
    stat_word[SB_DENS] = 1'b1;
    stat_word[SB_IE]   = st_q.ie;
    stat_word[SB_ACT]  = st_q.act;
    stat_word[SB_RDY]  = st_q.rdy;
    stat_word[SB_ERR]  = st_q.unsup | st_q.hard;
    stat_word[SB_HARD] = st_q.hard;
  end

  always_comb begin
    st_n    = st_q;
    irq_n   = irq_q;
    start_n = 1'b0;
    clr_n   = 1'b0;
    rd_n    = rd_q;
    if (rd_any) rd_n = rd_stat ? stat_word : '0;
    if (rd_stat) irq_n = 1'b0;
    if (eng_done && st_q.act) begin
      st_n.act = 1'b0;
      st_n.rdy = 1'b1;
      if (eng_hard_err) st_n.hard = 1'b1;
      if (st_q.ie) irq_n = 1'b1;
    end
    if (bad_acc) st_n.unsup = 1'b1;
    if (wr_ctrl) begin
      if (wdata[CB_FETCH]) begin
        if (!st_q.act) begin
          start_n  = 1'b1;
          st_n.act = 1'b1;
          st_n.rdy = 1'b0;
        end
      end else if (wdata[CB_IE]) begin
        if (st_q.rdy && !st_q.ie) irq_n = 1'b1;
        st_n.ie = 1'b1;
      end else if (wdata[CB_CLR]) begin
        st_n  = STAT_RST;
        irq_n = 1'b0;
        clr_n = 1'b1;
      end else begin
        st_n.unsup = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= STAT_RST;
      irq_q   <= 1'b0;
      start_q <= 1'b0;
      clr_q   <= 1'b0;
      rd_q    <= '0;
    end else begin
      st_q    <= st_n;
      irq_q   <= irq_n;
      start_q <= start_n;
      clr_q   <= clr_n;
      if (rd_any) rd_q <= rd_n;
    end
  end

  assign rd_data   = rd_q;
  assign irq       = irq_q;
  assign eng_start = start_q;
  assign eng_clear = clr_q;

  p_start_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q);
  p_start_act_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> (st_q.act && !st_q.rdy));
  p_act_rdy_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(st_q.act && st_q.rdy));
  p_irq_needs_ie_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> st_q.ie);
  p_stat_read_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !(eng_done && st_q.act) && !wr_ctrl) |=> !irq_q);
  p_clear_state_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_q |-> (st_q == STAT_RST && !irq_q));
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q.unsup && !wr_ctrl) |=> st_q.unsup);
endmodule

// File: rtl/cbw_top.sv
module cbw_top
  import cbw_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W,
  parameter int PW = PTR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic          acc_write,
  input  logic [AW-1:0] acc_addr,
  input  logic [DW-1:0] acc_wdata,
  output logic [DW-1:0] rd_data,
  output logic          irq,
  output logic          eng_start,
  output logic          eng_clear,
  output logic [PW-1:0] cb_ptr,
  input  logic          eng_done,
  input  logic          eng_hard_err
);
  logic [1:0] rsync_q;
  logic       rst_s_n;
  logic       rd_stat, wr_ctrl, wr_phi, wr_plo, bad_acc, rd_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s_n = rsync_q[1];

  assign rd_any = acc_valid && !acc_write;

  cbw_decode #(.AW(AW)) u_dec (
    .clk(clk), .rst_n(rst_s_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .rd_stat(rd_stat), .wr_ctrl(wr_ctrl),
    .wr_phi(wr_phi), .wr_plo(wr_plo), .bad_acc(bad_acc)
  );

  cbw_ptr #(.DW(DW), .PW(PW)) u_ptr (
    .clk(clk), .rst_n(rst_s_n), .wr_hi(wr_phi), .wr_lo(wr_plo),
    .wdata(acc_wdata), .ptr(cb_ptr)
  );

  cbw_ctl #(.DW(DW)) u_ctl (
    .clk(clk), .rst_n(rst_s_n), .rd_any(rd_any), .rd_stat(rd_stat),
    .wr_ctrl(wr_ctrl), .bad_acc(bad_acc), .wdata(acc_wdata),
    .eng_done(eng_done), .eng_hard_err(eng_hard_err), .rd_data(rd_data),
    .irq(irq), .eng_start(eng_start), .eng_clear(eng_clear)
  );
endmodule

// File: tb/cbw_top_tb_top.sv
module cbw_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, acc_write = 1'b0;
  logic [2:0]  acc_addr = '0;
  logic [15:0] acc_wdata = '0;
  logic [15:0] rd_data;
  logic        irq, eng_start, eng_clear;
  logic [23:0] cb_ptr;
  logic        eng_done = 1'b0, eng_hard_err = 1'b0;
  int          total = 0, bad = 0;
  bit          finished = 1'b0;

  always #10 clk = ~clk;

  cbw_top dut_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .rd_data(rd_data), .irq(irq),
    .eng_start(eng_start), .eng_clear(eng_clear), .cb_ptr(cb_ptr),
    .eng_done(eng_done), .eng_hard_err(eng_hard_err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input bit wr, input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = wr; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  task automatic done_pulse(input bit herr);
    @(negedge clk);
    eng_done = 1'b1; eng_hard_err = herr;
    @(negedge clk);
    eng_done = 1'b0; eng_hard_err = 1'b0;
  endtask

  task automatic stat_is(input logic [15:0] exp, input string tag);
    acc(1'b0, 3'd2, 16'h0);
    chk(rd_data === exp, tag, rd_data, exp);
  endtask

  task automatic dclear();
    acc(1'b1, 3'd3, 16'h0010);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] exp_st;
    bit          exp_irq;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(irq === 1'b0 && eng_start === 1'b0 && eng_clear === 1'b0, "R1 outputs", {irq, eng_start, eng_clear}, 0);
    stat_is(16'h8008, "R1 status");

    // R2 R10 read sweep over all offsets
    for (int a = 0; a < 8; a++) begin
      dclear();
      acc(1'b0, 3'(a), 16'h0);
      exp_st = (a == 2) ? 16'h8008 : 16'h0;
      chk(rd_data === exp_st, (a == 2) ? "R3 read status" : "R2 read zero", rd_data, exp_st);
      exp_st = (a == 4 || a == 6) ? 16'h8018 : 16'h8008;
      stat_is(exp_st, "R10 read offset err");
    end
    // R10 writes to offsets 4 and 6; R2 writes elsewhere have no effect
    for (int a = 0; a < 8; a++) begin
      if (a == 3) continue;
      dclear();
      acc(1'b1, 3'(a), 16'hFFFF);
      exp_st = (a == 4 || a == 6) ? 16'h8018 : 16'h8008;
      stat_is(exp_st, "R10 write offset err");
    end

    // R4 R5 R8 R10 control word sweep over bits 8:0
    for (int cw = 0; cw < 512; cw++) begin
      dclear();
      acc(1'b1, 3'd3, 16'(cw));
      exp_irq = 1'b0;
      if (cw[8]) begin
        exp_st = 16'h8004;
        chk(eng_start === 1'b1 && eng_clear === 1'b0, "R4 start pulse", {eng_start, eng_clear}, 2);
      end else if (cw[1]) begin
        exp_st = 16'h800A; exp_irq = 1'b1;
        chk(eng_start === 1'b0, "R5 no start", eng_start, 0);
      end else if (cw[4]) begin
        exp_st = 16'h8008;
        chk(eng_clear === 1'b1 && eng_start === 1'b0, "R8 clear pulse", {eng_start, eng_clear}, 1);
      end else begin
        exp_st = 16'h8018;
        chk(eng_start === 1'b0 && eng_clear === 1'b0, "R10 no pulse", {eng_start, eng_clear}, 0);
      end
      chk(irq === exp_irq, "R5 irq on enable", irq, exp_irq);
      stat_is(exp_st, "R4 R5 R8 R10 status after control");
      chk(irq === 1'b0, "R7 irq dropped by read", irq, 0);
    end

    // R4 start pulse lasts one cycle; fetch while active ignored
    dclear();
    acc(1'b1, 3'd3, 16'h0100);
    @(negedge clk);
    chk(eng_start === 1'b0, "R4 pulse width", eng_start, 0);
    acc(1'b1, 3'd3, 16'h0100);
    chk(eng_start === 1'b0, "R4 fetch while active", eng_start, 0);
    stat_is(16'h8004, "R4 status while active");
    // R8 clear aborts active
    dclear();
    chk(eng_clear === 1'b1, "R8 abort pulse", eng_clear, 1);
    stat_is(16'h8008, "R8 status after abort");

    // R5 enable while already enabled: no new irq
    dclear();
    acc(1'b1, 3'd3, 16'h0002);
    acc(1'b0, 3'd2, 16'h0);
    acc(1'b1, 3'd3, 16'h0002);
    chk(irq === 1'b0, "R5 no irq when already enabled", irq, 0);

    // R6 R7 done with IE -> irq held until status read
    acc(1'b1, 3'd3, 16'h0100);
    chk(irq === 1'b0, "R6 no irq while active", irq, 0);
    done_pulse(1'b0);
    chk(irq === 1'b1, "R6 irq on done", irq, 1);
    repeat (5) @(negedge clk);
    chk(irq === 1'b1, "R7 irq held", irq, 1);
    acc(1'b0, 3'd0, 16'h0);
    chk(irq === 1'b1, "R7 irq held across data read", irq, 1);
    stat_is(16'h800A, "R6 status after done");
    chk(irq === 1'b0, "R7 irq dropped", irq, 0);
    // R8 clear drops pending irq
    acc(1'b1, 3'd3, 16'h0100);
    done_pulse(1'b0);
    dclear();
    chk(irq === 1'b0, "R8 irq dropped by clear", irq, 0);

    // R6 done without IE; done while idle ignored
    dclear();
    acc(1'b1, 3'd3, 16'h0100);
    done_pulse(1'b0);
    chk(irq === 1'b0, "R6 no irq without enable", irq, 0);
    stat_is(16'h8008, "R6 ready after done");
    done_pulse(1'b1);
    stat_is(16'h8008, "R11 idle done ignored");

    // R11 hard error
    acc(1'b1, 3'd3, 16'h0100);
    done_pulse(1'b1);
    stat_is(16'h8058, "R11 hard error bits");
    dclear();
    stat_is(16'h8008, "R11 cleared");

    // R9 pointer sweep
    for (int i = 0; i < 16; i++) begin
      logic [15:0] hi, lo;
      logic [23:0] exp_p;
      hi = 16'(i * 16'h1357 + 16'hA500);
      lo = 16'(i * 16'h2468 + 16'h0F0F);
      exp_p = {hi[7:0], lo};
      acc(1'b1, 3'd5, hi);
      acc(1'b1, 3'd7, lo);
      chk(cb_ptr === exp_p, "R9 pointer", cb_ptr, exp_p);
      acc(1'b1, 3'd3, 16'h0002);
      acc(1'b0, 3'd2, 16'h0);
      acc(1'b1, 3'd4, 16'hFFFF);
      chk(cb_ptr === exp_p, "R9 pointer unchanged", cb_ptr, exp_p);
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule